// File: doc/BRIEF.md
# Cascadable Line Capture Register for a Column Driver

This block collects one horizontal line of gray-scale pixel data for a display column driver. Each clock carries a 36-bit word made of six 6-bit dots. After a start pulse, consecutive words are written into consecutive 36-bit groups of a wide line register. A direction input selects the order in which the groups are filled. It also selects which of the two start pins is the input and which one carries the cascade pulse to the next driver in a chain. The filled line register is presented to a downstream hold latch.

The line is normally `GROUPS` groups wide. In the reduced-width mode a band of `BAND_N` groups starting at group `BAND_AT` is skipped, and fewer groups are filled. A cascade pulse is issued when the last active group is written. Two clocks later the capture token retires by itself, and further words are dropped. Two inversion controls complement the lower and upper halves of each word as it is stored. A rising strobe edge, which marks the transfer of the line to the hold latch, cancels any active token.

Top module: `line_capture`

## Requirements
- R1: During and right after reset, every bit of `line_o` is 0, `idle_o` is 1, and both cascade outputs are 0.
- R2: A token is armed only on a clock where the selected start pin is high after being low on the previous clock. A start held high arms only once. Words presented while `idle_o` is 1 leave `line_o` unchanged.
- R3: With `dir_i`=1, the selected start pin is `start_r_i`. The k-th word after the arming edge (k from 0) is stored in fill position k. Group g occupies `line_o[g*36 +: 36]`, and dot d of a word occupies bits `[d*6 +: 6]` of its group.
- R4: With `dir_i`=0, the selected start pin is `start_l_i`, and the fill positions run in the reverse order: word k goes to position N-1-k, where N is the number of active groups. A pulse on the unselected start pin arms nothing.
- R5: The cascade pulse is high for exactly one cycle, following the N-th clock edge after the arming edge. It appears on `casc_l_o` when `dir_i`=1 and on `casc_r_o` when `dir_i`=0. The other cascade pin stays 0.
- R6: The token retires on the (N+2)-th edge after the arming edge. From the cycle after that edge, `idle_o` is 1 and further words are ignored.
- R7: With `wide_i`=1, N=`GROUPS` and fill position p is group p. With `wide_i`=0, N=`GROUPS-BAND_N`. Positions below `BAND_AT` map to the same group, and the rest map to group p+`BAND_N`. The band groups keep their contents.
- R8: When `inv_lo_i`=1, dots 0 to 2 (bits 17:0) are stored complemented. When `inv_hi_i`=1, dots 3 to 5 (bits 35:18) are stored complemented.
- R9: A rising edge on `stb_i` clears the token. The word on that edge is not stored, `idle_o` is 1 in the following cycle, and no cascade pulse follows. `line_o` keeps its contents.
- R10: `idle_o` is 0 from the cycle after the arming edge until the token retires or is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Fill direction and start/cascade pin roles, latched at arming |
| wide_i | input | 1 | 1: full width, 0: skip middle band; latched at arming |
| start_r_i | input | 1 | Start pulse when dir_i=1 |
| start_l_i | input | 1 | Start pulse when dir_i=0 |
| casc_r_o | output | 1 | Cascade pulse when dir_i=0 |
| casc_l_o | output | 1 | Cascade pulse when dir_i=1 |
| stb_i | input | 1 | Strobe; rising edge clears the token |
| inv_lo_i | input | 1 | Complement dots 0 to 2 at store |
| inv_hi_i | input | 1 | Complement dots 3 to 5 at store |
| din_i | input | 36 | Six 6-bit dots, dot 0 in bits 5:0 |
| line_o | output | GROUPS*36 | Captured line |
| idle_o | output | 1 | No capture token active |

## Verification
The bench builds the block with `GROUPS`=12, `BAND_AT`=5 and `BAND_N`=2. With these values one line takes 12 or 10 clocks, so a few hundred cycles cover many randomly mixed lines in both directions, both widths and all inversion settings. At that size the skipped band still sits strictly inside the line, so reversed fills cross it from both sides. The line register is short enough to be compared against a bench model group by group after every line.

// File: rtl/lcap_pkg.sv
package lcap_pkg;

    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_RUN  = 1'b1
    } tok_state_e;

    // Extra clocks the token stays alive after the last active group.
    localparam int unsigned TAIL_CLKS = 2;

    function automatic int unsigned active_groups(
        input logic        wide,
        input int unsigned total,
        input int unsigned band_n
    );
        return wide ? total : (total - band_n);
    endfunction

    // Map the sequence number of an incoming word to a physical group.
    function automatic int unsigned seq_to_group(
        input int unsigned seq,
        input logic        wide,
        input logic        dir,
        input int unsigned total,
        input int unsigned band_at,
        input int unsigned band_n
    );
        int unsigned n;
        int unsigned pos;
        n   = active_groups(wide, total, band_n);
        pos = dir ? seq : (n - 1 - seq);
        if (!wide && pos >= band_at)
            pos = pos + band_n;
        return pos;
    endfunction

endpackage

// File: rtl/lcap_token_ctrl.sv
module lcap_token_ctrl
    import lcap_pkg::*;
#(
    parameter int unsigned GROUPS  = 80,
    parameter int unsigned BAND_AT = 35,
    parameter int unsigned BAND_N  = 10,
    localparam int unsigned IW     = $clog2(GROUPS),
    localparam int unsigned CW     = $clog2(GROUPS + TAIL_CLKS + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_i,
    input  logic          wide_i,
    input  logic          start_r_i,
    input  logic          start_l_i,
    input  logic          stb_i,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_idx_o,
    output logic          wide_o,
    output logic          casc_r_o,
    output logic          casc_l_o,
    output logic          idle_o
);

    tok_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] n_act;
    logic          dir_q;
    logic          wide_q;
    logic          casc_q;
    logic          start_sel;
    logic          start_prev_q;
    logic          stb_prev_q;
    logic          arm;
    logic          stb_rise;

    assign start_sel = dir_i ? start_r_i : start_l_i;
    assign arm       = start_sel & ~start_prev_q;
    assign stb_rise  = stb_i & ~stb_prev_q;
    assign n_act     = CW'(active_groups(wide_q, GROUPS, BAND_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            start_prev_q <= 1'b0;
            stb_prev_q   <= 1'b0;
        end else begin
            start_prev_q <= start_sel;
            stb_prev_q   <= stb_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TOK_IDLE;
            cnt_q   <= '0;
            casc_q  <= 1'b0;
            dir_q   <= 1'b1;
            wide_q  <= 1'b1;
        end else if (stb_rise) begin
            state_q <= TOK_IDLE;
            cnt_q   <= '0;
            casc_q  <= 1'b0;
        end else if (arm) begin
            state_q <= TOK_RUN;
            cnt_q   <= '0;
            casc_q  <= 1'b0;
            dir_q   <= dir_i;
            wide_q  <= wide_i;
        end else if (state_q == TOK_RUN) begin
            cnt_q  <= cnt_q + 1'b1;
            casc_q <= (cnt_q == n_act - 1'b1);
            if (cnt_q == n_act + CW'(TAIL_CLKS - 1))
                state_q <= TOK_IDLE;
        end else begin
            casc_q <= 1'b0;
        end
    end

    assign wr_en_o  = (state_q == TOK_RUN) && (cnt_q < n_act) && !stb_rise && !arm;
    assign wr_idx_o = IW'(seq_to_group(int'(cnt_q), wide_q, dir_q, GROUPS, BAND_AT, BAND_N));
    assign wide_o   = wide_q;
    assign casc_l_o = casc_q & dir_q;
    assign casc_r_o = casc_q & ~dir_q;
    assign idle_o   = (state_q == TOK_IDLE);

    // R5: the cascade pulse lasts one cycle
    a_r5_casc_pulse: assert property (@(posedge clk) disable iff (rst)
        casc_q |=> !casc_q);

    // R9: a rising strobe leaves the token idle
    a_r9_strobe_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(stb_i) |=> idle_o);

    // R10: a cascade pulse only appears while a token is alive
    a_r10_casc_busy: assert property (@(posedge clk) disable iff (rst)
        casc_q |-> !idle_o);

endmodule

// File: rtl/lcap_word_invert.sv
module lcap_word_invert #(
    parameter int unsigned DOTS   = 6,
    parameter int unsigned DOT_W  = 6,
    localparam int unsigned WORD_W = DOTS * DOT_W
) (
    input  logic [WORD_W-1:0] din_i,
    input  logic              inv_lo_i,
    input  logic              inv_hi_i,
    output logic [WORD_W-1:0] dout_o
);

    for (genvar d = 0; d < DOTS; d++) begin : g_dot
        localparam bit LOW_HALF = (d < DOTS / 2);
        logic flip;
        assign flip = LOW_HALF ? inv_lo_i : inv_hi_i;
        assign dout_o[d*DOT_W +: DOT_W] = din_i[d*DOT_W +: DOT_W] ^ {DOT_W{flip}};
    end

    // R8: with both controls low the word passes unchanged
    always_comb begin
        if (!inv_lo_i && !inv_hi_i)
            a_r8_pass: assert (dout_o == din_i);
    end

endmodule

// File: rtl/lcap_line_store.sv
module lcap_line_store #(
    parameter int unsigned GROUPS  = 80,
    parameter int unsigned WORD_W  = 36,
    parameter int unsigned BAND_AT = 35,
    parameter int unsigned BAND_N  = 10,
    localparam int unsigned IW     = $clog2(GROUPS),
    localparam int unsigned LINE_W = GROUPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic              wide_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [LINE_W-1:0] line_o
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [WORD_W-1:0] grp_q;
        always_ff @(posedge clk) begin
            if (rst)
                grp_q <= '0;
            else if (wr_en_i && wr_idx_i == IW'(g))
                grp_q <= wdata_i;
        end
        assign line_o[g*WORD_W +: WORD_W] = grp_q;
    end

    // R7: no write lands in the skipped band in reduced-width mode
    a_r7_band_untouched: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wide_i) |->
            !((wr_idx_i >= IW'(BAND_AT)) && (wr_idx_i < IW'(BAND_AT + BAND_N))));

    // R3: write index always inside the line
    a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> (wr_idx_i < IW'(GROUPS)));

endmodule

// File: rtl/line_capture.sv
module line_capture
    import lcap_pkg::*;
#(
    parameter int unsigned GROUPS  = 80,
    parameter int unsigned DOTS    = 6,
    parameter int unsigned DOT_W   = 6,
    parameter int unsigned BAND_AT = 35,
    parameter int unsigned BAND_N  = 10,
    localparam int unsigned WORD_W = DOTS * DOT_W,
    localparam int unsigned LINE_W = GROUPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_i,
    input  logic              wide_i,
    input  logic              start_r_i,
    input  logic              start_l_i,
    output logic              casc_r_o,
    output logic              casc_l_o,
    input  logic              stb_i,
    input  logic              inv_lo_i,
    input  logic              inv_hi_i,
    input  logic [WORD_W-1:0] din_i,
    output logic [LINE_W-1:0] line_o,
    output logic              idle_o
);

    localparam int unsigned IW = $clog2(GROUPS);

    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic              wide_q;
    logic [WORD_W-1:0] wdata;

    lcap_token_ctrl #(
        .GROUPS (GROUPS),
        .BAND_AT(BAND_AT),
        .BAND_N (BAND_N)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .dir_i    (dir_i),
        .wide_i   (wide_i),
        .start_r_i(start_r_i),
        .start_l_i(start_l_i),
        .stb_i    (stb_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .wide_o   (wide_q),
        .casc_r_o (casc_r_o),
        .casc_l_o (casc_l_o),
        .idle_o   (idle_o)
    );

    lcap_word_invert #(
        .DOTS (DOTS),
        .DOT_W(DOT_W)
    ) u_inv (
        .din_i   (din_i),
        .inv_lo_i(inv_lo_i),
        .inv_hi_i(inv_hi_i),
        .dout_o  (wdata)
    );

    lcap_line_store #(
        .GROUPS (GROUPS),
        .WORD_W (WORD_W),
        .BAND_AT(BAND_AT),
        .BAND_N (BAND_N)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en),
        .wr_idx_i(wr_idx),
        .wide_i  (wide_q),
        .wdata_i (wdata),
        .line_o  (line_o)
    );

    // R6: while idle the line register does not move
    a_r6_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        idle_o |=> $stable(line_o));

    // R5: never both cascade pins at once
    a_r5_one_pin: assert property (@(posedge clk) disable iff (rst)
        !(casc_r_o && casc_l_o));

    // R1: reset leaves the block idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (idle_o && !casc_r_o && !casc_l_o));

endmodule

// File: tb/line_capture_test.sv
module line_capture_test;

    localparam int G   = 12;
    localparam int BAT = 5;
    localparam int BN  = 2;
    localparam int WW  = 36;
    localparam int LW  = G * WW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dir_i = 1'b1, wide_i = 1'b1;
    logic          start_r_i = 1'b0, start_l_i = 1'b0;
    logic          stb_i = 1'b0, inv_lo_i = 1'b0, inv_hi_i = 1'b0;
    logic [WW-1:0] din_i = '0;
    logic          casc_r_o, casc_l_o, idle_o;
    logic [LW-1:0] line_o;

    int errors = 0;
    int checks = 0;
    logic [WW-1:0] model [G];

    line_capture #(.GROUPS(G), .BAND_AT(BAT), .BAND_N(BN)) uut (
        .clk(clk), .rst(rst), .dir_i(dir_i), .wide_i(wide_i),
        .start_r_i(start_r_i), .start_l_i(start_l_i),
        .casc_r_o(casc_r_o), .casc_l_o(casc_l_o), .stb_i(stb_i),
        .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i), .din_i(din_i),
        .line_o(line_o), .idle_o(idle_o)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_group(int k, bit wide, bit dir);
        int n = wide ? G : G - BN;
        int p = dir ? k : n - 1 - k;
        if (!wide && p >= BAT) p = p + BN;
        return p;
    endfunction

    function automatic logic [WW-1:0] exp_word(logic [WW-1:0] w, bit lo, bit hi);
        return w ^ {{18{hi}}, {18{lo}}};
    endfunction

    task automatic cmp_line(input string req);
        int bad = -1;
        for (int g = 0; g < G; g++)
            if (line_o[g*WW +: WW] !== model[g] && bad < 0) bad = g;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, $sformatf("%s group %0d", req, bad), line_o[bad*WW +: WW], model[bad]);
    endtask

    // One full line: arm, feed N words plus extras, check cascade/idle each cycle.
    task automatic run_line(input bit dir, input bit wide, input bit lo, input bit hi, input bit hold);
        int n = wide ? G : G - BN;
        string tag;
        @(negedge clk);
        dir_i = dir; wide_i = wide; inv_lo_i = lo; inv_hi_i = hi;
        din_i = WW'({$urandom, $urandom});
        if (dir) start_r_i = 1'b1; else start_l_i = 1'b1;
        @(posedge clk);
        for (int e = 1; e <= n + 4; e++) begin
            logic [WW-1:0] w;
            @(negedge clk);
            if (!hold) begin start_r_i = 1'b0; start_l_i = 1'b0; end
            begin
                logic outp, otherp;
                outp   = dir ? casc_l_o : casc_r_o;
                otherp = dir ? casc_r_o : casc_l_o;
                chk(outp == (e - 1 == n), "R5 cascade", outp, (e - 1 == n));
                chk(otherp == 1'b0, "R5 other pin", otherp, 0);
                chk(idle_o == (e - 1 >= n + 2), (e - 1 >= n + 2) ? "R6 idle" : "R10 busy",
                    idle_o, (e - 1 >= n + 2));
            end
            w = WW'({$urandom, $urandom});
            din_i = w;
            if (e <= n) model[exp_group(e - 1, wide, dir)] = exp_word(w, lo, hi);
            @(posedge clk);
        end
        @(negedge clk);
        start_r_i = 1'b0; start_l_i = 1'b0;
        if (!wide) tag = "R7 reduced";
        else if (!dir) tag = "R4 reverse";
        else if (lo || hi) tag = "R8 invert";
        else if (hold) tag = "R2 held start";
        else tag = "R3 forward";
        cmp_line(tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_words(input int cnt, input string req);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            din_i = WW'({$urandom, $urandom});
        end
        @(negedge clk);
        chk(idle_o == 1'b1, req, idle_o, 1);
        cmp_line(req);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int g = 0; g < G; g++) model[g] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(line_o == '0, "R1 line", line_o[63:0], 0);
        chk(idle_o == 1'b1, "R1 idle", idle_o, 1);
        chk(casc_r_o == 1'b0 && casc_l_o == 1'b0, "R1 cascade", {casc_r_o, casc_l_o}, 0);

        // R2 data without a start pulse is dropped
        idle_words(6, "R2 no start");

        // Directed lines
        run_line(1, 1, 0, 0, 0);   // R3
        run_line(0, 1, 0, 0, 0);   // R4
        run_line(1, 0, 0, 0, 0);   // R7
        run_line(0, 0, 0, 0, 0);   // R7 reversed across band
        run_line(1, 1, 1, 0, 0);   // R8 low half
        run_line(0, 1, 0, 1, 0);   // R8 high half
        run_line(1, 1, 0, 0, 1);   // R2 held start arms once

        // R6 words after retirement are ignored
        idle_words(4, "R6 after stop");

        // R4 wrong start pin arms nothing
        @(negedge clk);
        dir_i = 1'b1; start_l_i = 1'b1;
        @(negedge clk);
        start_l_i = 1'b0;
        idle_words(4, "R4 wrong pin");
        @(negedge clk);
        dir_i = 1'b0; start_r_i = 1'b1;
        @(negedge clk);
        start_r_i = 1'b0;
        idle_words(4, "R4 wrong pin left");

        // R9 strobe in mid-line clears the token
        @(negedge clk);
        dir_i = 1'b1; wide_i = 1'b1; inv_lo_i = 1'b0; inv_hi_i = 1'b0;
        start_r_i = 1'b1;
        @(negedge clk);
        start_r_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            logic [WW-1:0] w;
            w = WW'({$urandom, $urandom});
            din_i = w;
            model[k] = w;
            @(negedge clk);
        end
        stb_i = 1'b1;
        din_i = WW'({$urandom, $urandom});
        @(negedge clk);
        chk(idle_o == 1'b1, "R9 strobe idle", idle_o, 1);
        stb_i = 1'b0;
        for (int i = 0; i < G + 3; i++) begin
            din_i = WW'({$urandom, $urandom});
            @(negedge clk);
            chk(casc_r_o == 1'b0 && casc_l_o == 1'b0, "R9 no cascade", {casc_r_o, casc_l_o}, 0);
        end
        cmp_line("R9 line kept");

        // Random lines, strobe between them
        for (int t = 0; t < 16; t++) begin
            run_line($urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) == 0);
            stb_i = 1'b1;
            @(negedge clk);
            stb_i = 1'b0;
            repeat (2) @(negedge clk);
        end

        finish_run();
    end

endmodule